// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt lines from up to 64 sources, latches a rising edge on each line as a pending flag, and offers the CPU one request at a time together with the number of the source to service. Each source has a one-byte control register on a byte-wide register bus. That register holds a three-bit priority level, a disable (mask) bit and the pending flag. The same mask bits can also be reached through a small group of mask bytes, with eight sources per byte, so software can enable or disable sources in bulk.

An in-service register holds one bit per priority level. When the CPU acknowledges a request, the bit for that level is set and the chosen source's pending flag is cleared. From then on, requests at that level and at every lower level are held back. An end-of-service strobe retires the most urgent level in service. A flag that is latched while its source is masked stays set, and it is delivered once the mask is lifted unless software clears it first.

Address map (9-bit bus address). Mask byte k sits at 0x000+k. The control register of source n sits at 0x100+2·n. The in-service register sits at 0x1F0. Level 0 is the most urgent and level 7 the least urgent.

Top module: `vpic_top`

## Requirements
- R1: The control register of source n is at address 0x100+2·n and reads as {pending in bit 7, mask in bit 6, zeros in bits 5:3, level in bits 2:0}. A write loads the level and the mask, and the written bit 7 becomes the pending flag: 1 sets it and 0 clears it.
- R2: Mask byte k is at address 0x000+k. Its bit j is the mask of source 8k+j, and 1 means disabled. Writing the byte replaces all eight masks (0xFF disables all eight), and a write through either view can be read back through the other.
- R3: After reset all pending flags and in-service bits are 0, every mask bit is 1, every level is 7 (each control register reads 0x47) and irqReq is low.
- R4: A rising edge on irqIn[n] sets the pending flag of source n even while n is masked. The flag stays set until software or an acknowledge clears it.
- R5: A source that became pending while masked raises irqReq with its number on the first cycle after the clock edge that clears its mask.
- R6: irqReq is high when some source is pending, unmasked and not blocked. irqVector then gives the eligible source with the most urgent level, the lowest source number winning a tie, and irqLevel gives that level.
- R7: A source at level L is blocked while any in-service bit j with j ≤ L is set.
- R8: intAck while irqReq is high clears the chosen source's pending flag and sets in-service bit irqLevel at the same clock edge. intAck while irqReq is low changes nothing.
- R9: eoiStrobe clears the lowest-numbered set in-service bit. When it coincides with intAck, the bit is taken from the old value and the acknowledged level's bit is then set.
- R10: The in-service register reads at address 0x1F0 with bit L standing for level L, and bus writes to it are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | NUM_SRC | Interrupt lines, rising edge latched |
| busAddr | input | 9 | Register byte address |
| busWrEn | input | 1 | Write strobe for the addressed byte |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| irqReq | output | 1 | An eligible interrupt is offered |
| irqVector | output | 6 | Number of the offered source |
| irqLevel | output | 3 | Level of the offered source |
| intAck | input | 1 | CPU acknowledge of the offered request |
| eoiStrobe | input | 1 | End of service of the most urgent active level |

## Verification
Every state change (an edge capture, a bus write, an acknowledge or an end-of-service) takes effect at the clock edge on which it is presented. irqReq, irqVector and irqLevel follow from the registers through logic only, so they are due just after that same edge, and busRdData is due in the same cycle as busAddr. The bench therefore drives inputs on the falling edge, samples the request outputs 1 ns after the next rising edge, and reads registers 1 ns after the address is set. It compares all of these against a model of pending, mask, level and in-service state that it keeps itself, and it sweeps a 16-source configuration with pseudo-random control bytes and mixed acknowledge and end-of-service sequences.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int SRC_IDX_W  = 6;
  localparam int LEVEL_W    = 3;
  localparam int NUM_LEVELS = 1 << LEVEL_W;
  localparam int BUS_ADDR_W = 9;
  localparam int DATA_W     = 8;

  localparam logic [BUS_ADDR_W-1:0] ADDR_ISR = 9'h1F0;

  // strobes from control to datapath
  typedef struct packed {
    logic                 ack;
    logic [SRC_IDX_W-1:0] ackSrc;
    logic [LEVEL_W-1:0]   ackLevel;
    logic                 eoi;
  } ctrlStrobe_t;
endpackage

// File: rtl/vpic_regfile.sv
module vpic_regfile
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_SRC-1:0]                 irqIn,
  input  logic [BUS_ADDR_W-1:0]              busAddr,
  input  logic                               busWrEn,
  input  logic [DATA_W-1:0]                  busWrData,
  output logic [DATA_W-1:0]                  busRdData,
  input  ctrlStrobe_t                        strobe,
  output logic [NUM_SRC-1:0]                 pendQ,
  output logic [NUM_SRC-1:0]                 maskQ,
  output logic [NUM_SRC-1:0][LEVEL_W-1:0]    prioQ,
  output logic [NUM_LEVELS-1:0]              isrQ
);
  localparam int BYTE_CNT = NUM_SRC / 8;
  localparam logic [7:0] SRC_LIMIT  = 8'(NUM_SRC);
  localparam logic [7:0] BYTE_LIMIT = 8'(BYTE_CNT);

  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] edgeHit;
  logic ctrlHit, maskHit, isrHit;
  logic [NUM_LEVELS-1:0] isrLow, isrNext;

  // address decode
  assign ctrlHit = busAddr[8] && !busAddr[0] && ({1'b0, busAddr[7:1]} < SRC_LIMIT);
  assign maskHit = !busAddr[8] && (busAddr[7:0] < BYTE_LIMIT);
  assign isrHit  = (busAddr == ADDR_ISR);

  // edge capture
  always_ff @(posedge clk) begin
    if (rst) irqPrev <= '0;
    else     irqPrev <= irqIn;
  end
  assign edgeHit = irqIn & ~irqPrev;

  // per-source state
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic selCtrl, selMask, ackHit;
    assign selCtrl = ctrlHit && busWrEn && (busAddr[7:1] == 7'(i));
    assign selMask = maskHit && busWrEn && (busAddr[7:0] == 8'(i / 8));
    assign ackHit  = strobe.ack && (strobe.ackSrc == SRC_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pendQ[i] <= 1'b0;
        maskQ[i] <= 1'b1;
        prioQ[i] <= '1;
      end else begin
        if (selCtrl) prioQ[i] <= busWrData[LEVEL_W-1:0];
        if (selCtrl)      maskQ[i] <= busWrData[6];
        else if (selMask) maskQ[i] <= busWrData[i % 8];
        pendQ[i] <= edgeHit[i] | (selCtrl ? busWrData[7] : (pendQ[i] & ~ackHit));
      end
    end

    // R4: an edge is latched whatever the mask
    a_r4_edge_latched: assert property (@(posedge clk) disable iff (rst)
      edgeHit[i] |=> pendQ[i]);
  end

  // in-service tracking
  assign isrLow  = isrQ & (~isrQ + NUM_LEVELS'(1));
  assign isrNext = (strobe.eoi ? (isrQ & ~isrLow) : isrQ)
                 | (strobe.ack ? (NUM_LEVELS'(1) << strobe.ackLevel) : '0);

  always_ff @(posedge clk) begin
    if (rst) isrQ <= '0;
    else     isrQ <= isrNext;
  end

  // read mux
  always_comb begin
    busRdData = '0;
    if (ctrlHit) begin
      for (int n = 0; n < NUM_SRC; n++)
        if (busAddr[7:1] == 7'(n))
          busRdData = {pendQ[n], maskQ[n], 3'b000, prioQ[n]};
    end else if (maskHit) begin
      for (int k = 0; k < BYTE_CNT; k++)
        if (busAddr[7:0] == 8'(k))
          busRdData = maskQ[8*k +: 8];
    end else if (isrHit) begin
      busRdData = isrQ;
    end
  end

  // R3: reset leaves everything disabled and idle
  a_r3_reset_state: assert property (@(posedge clk)
    rst |=> (&maskQ) && (pendQ == '0) && (isrQ == '0));

  // R8: acknowledged level becomes in service
  a_r8_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
    strobe.ack |=> isrQ[$past(strobe.ackLevel)]);

  // R9: a lone end-of-service retires exactly one level
  a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
    (strobe.eoi && !strobe.ack && (isrQ != '0)) |=>
      ($countones(isrQ) == $countones($past(isrQ)) - 1));

  // R10: bus cannot write the in-service register
  a_r10_isr_readonly: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && isrHit && !strobe.ack && !strobe.eoi) |=> $stable(isrQ));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              pendQ,
  input  logic [NUM_SRC-1:0]              maskQ,
  input  logic [NUM_SRC-1:0][LEVEL_W-1:0] prioQ,
  input  logic [NUM_LEVELS-1:0]           isrQ,
  output logic                            found,
  output logic [SRC_IDX_W-1:0]            bestIdx,
  output logic [LEVEL_W-1:0]              bestLevel
);
  logic [NUM_LEVELS-1:0] levelOpen;
  logic [NUM_LEVELS-1:0] levelHit;
  logic [NUM_SRC-1:0]    elig;

  // a level stays open only while no equal or more urgent level is in service
  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      blk = blk | isrQ[l];
      levelOpen[l] = ~blk;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pendQ[i] & ~maskQ[i] & levelOpen[prioQ[i]];
  end

  always_comb begin
    levelHit = '0;
    for (int n = 0; n < NUM_SRC; n++)
      if (elig[n]) levelHit[prioQ[n]] = 1'b1;
    found = |levelHit;
    bestLevel = '1;
    for (int l = NUM_LEVELS - 1; l >= 0; l--)
      if (levelHit[l]) bestLevel = LEVEL_W'(l);
    bestIdx = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--)
      if (elig[n] && (prioQ[n] == bestLevel)) bestIdx = SRC_IDX_W'(n);
  end

  // R6: the offered source is pending, unmasked and in range
  a_r6_offer_valid: assert property (@(posedge clk) disable iff (rst)
    found |-> (pendQ[bestIdx] && !maskQ[bestIdx] && (int'(bestIdx) < NUM_SRC)
               && (prioQ[bestIdx] == bestLevel)));

  // R7: nothing at or above an in-service level is offered
  a_r7_not_blocked: assert property (@(posedge clk) disable iff (rst)
    found |-> ((isrQ & ((NUM_LEVELS'(2) << bestLevel) - NUM_LEVELS'(1))) == '0));
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
(
  input  logic                 found,
  input  logic [SRC_IDX_W-1:0] bestIdx,
  input  logic [LEVEL_W-1:0]   bestLevel,
  input  logic                 intAck,
  input  logic                 eoiStrobe,
  output ctrlStrobe_t          strobe,
  output logic                 irqReq,
  output logic [SRC_IDX_W-1:0] irqVector,
  output logic [LEVEL_W-1:0]   irqLevel
);
  assign irqReq    = found;
  assign irqVector = bestIdx;
  assign irqLevel  = bestLevel;

  // an acknowledge only counts while a request is offered (R8)
  always_comb begin
    strobe.ack      = intAck & found;
    strobe.ackSrc   = bestIdx;
    strobe.ackLevel = bestLevel;
    strobe.eoi      = eoiStrobe;
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    irqIn,
  input  logic [8:0]            busAddr,
  input  logic                  busWrEn,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  output logic                  irqReq,
  output logic [5:0]            irqVector,
  output logic [2:0]            irqLevel,
  input  logic                  intAck,
  input  logic                  eoiStrobe
);
  logic [NUM_SRC-1:0]              pendQ, maskQ;
  logic [NUM_SRC-1:0][LEVEL_W-1:0] prioQ;
  logic [NUM_LEVELS-1:0]           isrQ;
  logic                            found;
  logic [SRC_IDX_W-1:0]            bestIdx;
  logic [LEVEL_W-1:0]              bestLevel;
  ctrlStrobe_t                     strobe;

  initial begin
    a_r2_src_count: assert (NUM_SRC % 8 == 0 && NUM_SRC >= 8 && NUM_SRC <= 64);
  end

  vpic_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .irqIn(irqIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .strobe(strobe), .pendQ(pendQ), .maskQ(maskQ), .prioQ(prioQ), .isrQ(isrQ)
  );

  vpic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst(rst), .pendQ(pendQ), .maskQ(maskQ), .prioQ(prioQ), .isrQ(isrQ),
    .found(found), .bestIdx(bestIdx), .bestLevel(bestLevel)
  );

  vpic_ctrl u_ctrl (
    .found(found), .bestIdx(bestIdx), .bestLevel(bestLevel),
    .intAck(intAck), .eoiStrobe(eoiStrobe), .strobe(strobe),
    .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel)
  );
endmodule

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irqIn = '0;
  logic [8:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic irqReq;
  logic [5:0] irqVector;
  logic [2:0] irqLevel;
  logic intAck = 1'b0;
  logic eoiStrobe = 1'b0;

  always #2.5 clk = ~clk;

  vpic_top #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .irqIn(irqIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq),
    .irqVector(irqVector), .irqLevel(irqLevel), .intAck(intAck), .eoiStrobe(eoiStrobe)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;
  bit pendM [N];
  bit maskM [N];
  bit [2:0] prioM [N];
  bit [7:0] isrM;
  logic [31:0] lfsr = 32'hACE1_2345;

  function automatic logic [31:0] nextRand(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [8:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [8:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    irqIn[n] = 1'b1;
    @(posedge clk); #1;
    irqIn[n] = 1'b0;
    pendM[n] = 1'b1;
  endtask

  task automatic strobes(bit a, bit e);
    bit f; int idx, lvl;
    bit [7:0] low;
    expBest(f, idx, lvl);
    @(negedge clk);
    intAck = a; eoiStrobe = e;
    @(posedge clk); #1;
    intAck = 1'b0; eoiStrobe = 1'b0;
    low = isrM & (~isrM + 8'd1);
    if (e) isrM = isrM & ~low;
    if (a && f) begin
      pendM[idx] = 1'b0;
      isrM = isrM | (8'd1 << lvl);
    end
  endtask

  function automatic void expBest(output bit f, output int idx, output int lvl);
    f = 1'b0; idx = 0; lvl = 8;
    for (int n = 0; n < N; n++) begin
      bit open;
      open = ((isrM & ((8'd2 << prioM[n]) - 8'd1)) == 8'd0);
      if (pendM[n] && !maskM[n] && open && (int'(prioM[n]) < lvl)) begin
        f = 1'b1; idx = n; lvl = int'(prioM[n]);
      end
    end
  endfunction

  task automatic checkOffer(string tag);
    bit f; int idx, lvl;
    expBest(f, idx, lvl);
    check(irqReq == f, {tag, " irqReq"}, int'(irqReq), int'(f));
    if (f && irqReq) begin
      check(int'(irqVector) == idx, {tag, " irqVector"}, int'(irqVector), idx);
      check(int'(irqLevel) == lvl, {tag, " irqLevel"}, int'(irqLevel), lvl);
    end
  endtask

  function automatic logic [7:0] ctrlByte(int n);
    return {pendM[n], maskM[n], 3'b000, prioM[n]};
  endfunction

  task automatic checkCtrl(int n, string tag);
    logic [7:0] d;
    busRead(9'h100 + 9'(2 * n), d);
    check(d == ctrlByte(n), tag, int'(d), int'(ctrlByte(n)));
  endtask

  task automatic checkIsr(string tag);
    logic [7:0] d;
    busRead(9'h1F0, d);
    check(d == isrM, tag, int'(d), int'(isrM));
  endtask

  task automatic checkMaskByte(int k, string tag);
    logic [7:0] d, e;
    for (int j = 0; j < 8; j++) e[j] = maskM[8 * k + j];
    busRead(9'(k), d);
    check(d == e, tag, int'(d), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int n = 0; n < N; n++) begin pendM[n] = 0; maskM[n] = 1; prioM[n] = 3'd7; end
    isrM = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R3 reset state
    check(irqReq == 1'b0, "R3 irqReq after reset", int'(irqReq), 0);
    for (int n = 0; n < N; n++) checkCtrl(n, "R3 control byte after reset");
    for (int k = 0; k < N / 8; k++) checkMaskByte(k, "R3 mask byte after reset");
    checkIsr("R3 in-service after reset");

    // R4 edges latched while masked
    for (int n = 0; n < N; n++) pulse(n);
    check(irqReq == 1'b0, "R4 no request while masked", int'(irqReq), 0);
    for (int n = 0; n < N; n++) checkCtrl(n, "R4 pending latched while masked");

    // R1 control write: clear pending, keep mask, load level
    for (int n = 0; n < N; n++) begin
      pendM[n] = 0; maskM[n] = 1; prioM[n] = 3'(n % 8);
      busWrite(9'h100 + 9'(2 * n), 8'h40 | 8'(n % 8));
    end
    for (int n = 0; n < N; n++) checkCtrl(n, "R1 control write readback");

    // R2 mask bytes alias the mask bits in both directions
    busWrite(9'h000, 8'h5A); busWrite(9'h001, 8'hC3);
    for (int j = 0; j < 8; j++) begin maskM[j] = 1'((8'h5A >> j) & 1); maskM[8 + j] = 1'((8'hC3 >> j) & 1); end
    for (int n = 0; n < N; n++) checkCtrl(n, "R2 mask byte seen in control byte");
    busWrite(9'h100 + 9'(2 * 3), {1'b0, 1'b1, 3'b000, prioM[3]}); maskM[3] = 1;
    busWrite(9'h100 + 9'(2 * 9), {1'b0, 1'b0, 3'b000, prioM[9]}); maskM[9] = 0;
    checkMaskByte(0, "R2 control mask seen in mask byte 0");
    checkMaskByte(1, "R2 control mask seen in mask byte 1");
    busWrite(9'h000, 8'hFF); busWrite(9'h001, 8'hFF);
    for (int n = 0; n < N; n++) maskM[n] = 1;
    for (int n = 0; n < N; n++) checkCtrl(n, "R2 0xFF disables all eight");

    // R5 pending while masked, delivered on unmask
    pulse(9);
    checkOffer("R5 masked source not offered");
    busWrite(9'h001, 8'hFD); maskM[9] = 0;
    checkOffer("R5 offered after unmask");
    check(irqReq && irqVector == 6'd9, "R5 vector after unmask", int'(irqVector), 9);
    // cleared while masked is not delivered
    busWrite(9'h001, 8'hFF); maskM[9] = 1;
    busWrite(9'h100 + 9'(18), {1'b0, 1'b1, 3'b000, prioM[9]}); pendM[9] = 0;
    busWrite(9'h001, 8'hFD); maskM[9] = 0;
    check(irqReq == 1'b0, "R5 cleared pending not delivered", int'(irqReq), 0);

    // R8 acknowledge without a request is ignored
    strobes(1'b1, 1'b0);
    checkIsr("R8 ack without request ignored");

    // R6 selection sweep over random control bytes
    for (int t = 0; t < 300; t++) begin
      for (int n = 0; n < N; n++) begin
        logic [7:0] b;
        lfsr = nextRand(lfsr); lfsr = nextRand(lfsr);
        b = lfsr[7:0] & 8'hC7;
        if (t % 3 == 0) b[2:0] = 3'd2;   // force ties
        pendM[n] = b[7]; maskM[n] = b[6]; prioM[n] = b[2:0];
        busWrite(9'h100 + 9'(2 * n), b);
      end
      checkOffer("R6 best level, lowest index");
    end

    // R7 R8 R9 acknowledge and end-of-service sequences
    for (int t = 0; t < 400; t++) begin
      int op, src;
      lfsr = nextRand(lfsr); lfsr = nextRand(lfsr); lfsr = nextRand(lfsr);
      op = int'(lfsr[2:0]) % 5;
      src = int'(lfsr[11:8]) % N;
      case (op)
        0: begin
          prioM[src] = lfsr[18:16]; pendM[src] = 1; maskM[src] = 0;
          busWrite(9'h100 + 9'(2 * src), {2'b10, 3'b000, prioM[src]});
        end
        1: begin
          bit f; int idx, lvl;
          expBest(f, idx, lvl);
          strobes(1'b1, 1'b0);
          if (f) checkCtrl(idx, "R8 ack clears pending");
        end
        2: strobes(1'b0, 1'b1);
        3: strobes(1'b1, 1'b1);
        default: pulse(src);
      endcase
      checkOffer("R7 offer respects in-service levels");
      checkIsr("R9 in-service after strobes");
    end

    // R10 in-service is read-only; unmapped reads zero
    busWrite(9'h1F0, ~isrM);
    checkIsr("R10 write to in-service ignored");
    busRead(9'h0FF, d);
    check(d == 8'h00, "R10 unmapped read", int'(d), 0);
    busRead(9'h101, d);
    check(d == 8'h00, "R10 odd control address read", int'(d), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule